// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps time of day and calendar date in packed binary coded decimal. It holds seconds, minutes, hours, day of week, date, month and a two-digit year, and it steps them once per pulse on a one-pulse-per-second tick input. Each field keeps its tens digit in the upper nibble and its units digit in the lower nibble. The counters appear as eight byte-wide registers in the top eight locations of the address space. A synchronous bus reaches them, and read data comes back one cycle after the request.

Software uses a transfer-control byte to work with the counters. A freeze bit holds the copy that software sees, so a read of several bytes stays coherent while the counters keep running. A hold bit stops counting and opens a staging copy for new values. Clearing the hold bit moves the staged values into the counters, and any second that arrived during the hold is added then. Three control flags are packed into the spare top bits of the time registers: a stop flag for the oscillator, a kick-start flag and a frequency-test flag. Calibration sign and magnitude bits are stored in the control byte and have no effect on counting.

Top module: `tod_calendar_rf`

## Requirements
- R1: After reset, reading offsets 0 to 7 returns 0x00, 0x00, 0x00, 0x00, 0x01, 0x01, 0x01 and 0x00 in that order.
- R2: The eight registers sit at the top eight addresses, where offset = address[2:0]. Offset 0 is control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month and 7 year. Any other address reads 0x00, and writes to it change nothing.
- R3: When counting, a tick raises seconds by one in BCD. Seconds go from 59 to 00 and carry into minutes, minutes go from 59 to 00 and carry into hours, and hours go from 23 to 00.
- R4: The hour carry steps the day of week, which goes from 07 to 01, and steps the date.
- R5: The date goes back to 01 after the last day of its month (31, or 30 for months 04, 06, 09 and 11) and carries into the month. The month goes from 12 to 01 and carries into the year, and the year goes from 99 to 00.
- R6: February has 29 days when the BCD year is a multiple of four and 28 days otherwise.
- R7: Seconds bit 7 is the stop flag. While it is set, ticks are dropped and the counters do not move. It is written by any write to offset 1.
- R8: Control bit 7 is the hold flag. Setting it copies the counters into staging. Writes to time fields update staging only while the flag is set, and are ignored while it is clear. Clearing it loads staging into the counters.
- R9: A tick that arrives during a hold, with the stop flag clear, is kept and added to the staged values when the hold is cleared.
- R10: Control bit 6 is the freeze flag. While it is set, reads of time fields return the values from the moment it was set, and counting goes on underneath. After it is cleared, reads follow the counters again.
- R11: Hours bit 7 (kick-start) and day-of-week bit 6 (frequency test) are stored on any write to their byte, read back, and are left unchanged by counting.
- R12: Control bits 5:0 read back as written and do not affect counting. Bits outside each field and its flags read as 0.
- R13: Read data appears on the rising edge after the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| bus_en | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The situation hardest to reach from the ports is a tick that lands during a hold. It must not be lost, yet it must not reach the running counters before the transfer. The bench sets the hold flag, writes a new seconds and minutes value, pulses the tick, and only then clears the hold. It expects the loaded seconds plus one. The calendar corners (a leap and a common February, a 30-day month, year 99 on December 31) are reached by staging a value one tick short of each boundary. A behavioural model of the register file is compared with the read data on every clock.

// File: rtl/tod_pkg.sv
package tod_pkg;

  // Register offsets inside the eight-byte window
  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_SEC  = 3'd1;
  localparam logic [2:0] OFS_MIN  = 3'd2;
  localparam logic [2:0] OFS_HOUR = 3'd3;
  localparam logic [2:0] OFS_DOW  = 3'd4;
  localparam logic [2:0] OFS_DATE = 3'd5;
  localparam logic [2:0] OFS_MON  = 3'd6;
  localparam logic [2:0] OFS_YEAR = 3'd7;

  // Control byte bit positions
  localparam int CTL_HOLD   = 7;
  localparam int CTL_FREEZE = 6;

  // Field widths
  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int DOW_W  = 3;
  localparam int DATE_W = 6;
  localparam int MON_W  = 5;
  localparam int YEAR_W = 8;

  typedef struct packed {
    logic [YEAR_W-1:0] yr;
    logic [MON_W-1:0]  mon;
    logic [DATE_W-1:0] date;
    logic [DOW_W-1:0]  dow;
    logic [HOUR_W-1:0] hr;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } tod_t;

  localparam tod_t TOD_RESET = '{yr: 8'h00, mon: 5'h01, date: 6'h01, dow: 3'd1,
                                 hr: 6'h00, min: 7'h00, sec: 7'h00};

endpackage

// File: rtl/tod_rst_sync.sv
module tod_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/tod_bcd_step.sv
// One packed-BCD field: steps by one when enabled, wraps to LO at or above hi.
module tod_bcd_step #(
  parameter int             W  = 7,
  parameter logic [W-1:0]   LO = '0
) (
  input  logic         en,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] hi,
  output logic [W-1:0] nxt,
  output logic         carry
);

  logic at_top;
  logic [W-1:0] inc;

  assign at_top = (cur >= hi);
  assign carry  = en & at_top;

  generate
    if (W > 4) begin : g_two_digit
      always_comb begin
        if (cur[3:0] >= 4'd9) inc = {cur[W-1:4] + 1'b1, 4'd0};
        else                  inc = {cur[W-1:4], cur[3:0] + 4'd1};
      end
    end else begin : g_one_digit
      always_comb inc = cur + W'(1);
    end
  endgenerate

  always_comb begin
    nxt = cur;
    if (en) nxt = at_top ? LO : inc;
  end

endmodule

// File: rtl/tod_month_days.sv
// Last valid date (BCD) for a month, with the leap rule on the BCD year.
module tod_month_days (
  input  logic [4:0] mon,
  input  logic [7:0] yr,
  output logic [5:0] last_day
);

  logic leap;

  always_comb begin
    if (yr[4]) leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  end

  always_comb begin
    case (mon)
      5'h02:                      last_day = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
      default:                    last_day = 6'h31;
    endcase
  end

endmodule

// File: rtl/tod_advance.sv
// Ripple-carry chain of BCD fields for one second step.
module tod_advance
  import tod_pkg::*;
(
  input  logic step,
  input  tod_t cur,
  output tod_t nxt
);

  logic c_sec, c_min, c_hr, c_date, c_mon, c_yr, c_dow;
  logic [DATE_W-1:0] last_day;

  tod_month_days u_mdays (.mon(cur.mon), .yr(cur.yr), .last_day(last_day));

  tod_bcd_step #(.W(SEC_W), .LO('0)) u_sec (
    .en(step), .cur(cur.sec), .hi(7'h59), .nxt(nxt.sec), .carry(c_sec));
  tod_bcd_step #(.W(MIN_W), .LO('0)) u_min (
    .en(c_sec), .cur(cur.min), .hi(7'h59), .nxt(nxt.min), .carry(c_min));
  tod_bcd_step #(.W(HOUR_W), .LO('0)) u_hr (
    .en(c_min), .cur(cur.hr), .hi(6'h23), .nxt(nxt.hr), .carry(c_hr));
  tod_bcd_step #(.W(DOW_W), .LO(3'd1)) u_dow (
    .en(c_hr), .cur(cur.dow), .hi(3'd7), .nxt(nxt.dow), .carry(c_dow));
  tod_bcd_step #(.W(DATE_W), .LO(6'h01)) u_date (
    .en(c_hr), .cur(cur.date), .hi(last_day), .nxt(nxt.date), .carry(c_date));
  tod_bcd_step #(.W(MON_W), .LO(5'h01)) u_mon (
    .en(c_date), .cur(cur.mon), .hi(5'h12), .nxt(nxt.mon), .carry(c_mon));
  tod_bcd_step #(.W(YEAR_W), .LO('0)) u_yr (
    .en(c_mon), .cur(cur.yr), .hi(8'h99), .nxt(nxt.yr), .carry(c_yr));

  logic unused_carries;
  assign unused_carries = c_yr ^ c_dow;

endmodule

// File: rtl/tod_calendar_rf.sv
module tod_calendar_rf
  import tod_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);

  localparam int WIN_HI = ADDR_W - 1;

  logic srst_n;
  tod_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  // ---------------- state ----------------
  tod_t live_q, stage_q, view_q;
  tod_t live_d, stage_d, view_d;
  logic hold_q, freeze_q, pend_q, stop_q, kick_q, ftest_q;
  logic hold_d, freeze_d, pend_d, stop_d, kick_d, ftest_d;
  logic [5:0] cal_q, cal_d;
  logic [7:0] rdata_d;

  // ---------------- decode ----------------
  logic       in_win, wr_any, rd_req, wr_ctrl;
  logic [2:0] ofs;
  logic       tick_ok, hold_set, hold_clr;

  assign in_win   = &bus_addr[WIN_HI:3];
  assign ofs      = bus_addr[2:0];
  assign wr_any   = bus_en & bus_we & in_win;
  assign rd_req   = bus_en & ~bus_we;
  assign wr_ctrl  = wr_any & (ofs == OFS_CTRL);
  assign tick_ok  = tick_1hz & ~stop_q;
  assign hold_set = wr_ctrl &  bus_wdata[CTL_HOLD] & ~hold_q;
  assign hold_clr = wr_ctrl & ~bus_wdata[CTL_HOLD] &  hold_q;

  // ---------------- advance path (shared) ----------------
  tod_t adv_src, adv_out;
  logic adv_step;

  assign adv_src  = hold_q ? stage_q : live_q;
  assign adv_step = hold_q ? (pend_q | tick_ok) : tick_ok;

  tod_advance u_adv (.step(adv_step), .cur(adv_src), .nxt(adv_out));

  // ---------------- next state ----------------
  always_comb begin
    live_d = live_q;
    if ((!hold_q && !hold_set) || hold_clr) live_d = adv_out;
  end

  always_comb begin
    stage_d = stage_q;
    if (hold_set) begin
      stage_d = live_q;
    end else if (hold_q && !hold_clr && wr_any) begin
      case (ofs)
        OFS_SEC:  stage_d.sec  = bus_wdata[SEC_W-1:0];
        OFS_MIN:  stage_d.min  = bus_wdata[MIN_W-1:0];
        OFS_HOUR: stage_d.hr   = bus_wdata[HOUR_W-1:0];
        OFS_DOW:  stage_d.dow  = bus_wdata[DOW_W-1:0];
        OFS_DATE: stage_d.date = bus_wdata[DATE_W-1:0];
        OFS_MON:  stage_d.mon  = bus_wdata[MON_W-1:0];
        OFS_YEAR: stage_d.yr   = bus_wdata[YEAR_W-1:0];
        default:  stage_d      = stage_q;
      endcase
    end
  end

  always_comb begin
    if (hold_set)                 pend_d = tick_ok;
    else if (hold_q && !hold_clr) pend_d = pend_q | tick_ok;
    else                          pend_d = 1'b0;
  end

  assign view_d = freeze_q ? view_q : live_q;

  always_comb begin
    hold_d   = hold_q;
    freeze_d = freeze_q;
    cal_d    = cal_q;
    stop_d   = stop_q;
    kick_d   = kick_q;
    ftest_d  = ftest_q;
    if (wr_ctrl) begin
      hold_d   = bus_wdata[CTL_HOLD];
      freeze_d = bus_wdata[CTL_FREEZE];
      cal_d    = bus_wdata[5:0];
    end
    if (wr_any && ofs == OFS_SEC)  stop_d  = bus_wdata[7];
    if (wr_any && ofs == OFS_HOUR) kick_d  = bus_wdata[7];
    if (wr_any && ofs == OFS_DOW)  ftest_d = bus_wdata[6];
  end

  // ---------------- read mux ----------------
  logic [7:0] rd_mux;

  always_comb begin
    rd_mux = 8'h00;
    if (in_win) begin
      case (ofs)
        OFS_CTRL: rd_mux = {hold_q, freeze_q, cal_q};
        OFS_SEC:  rd_mux = {stop_q, view_q.sec};
        OFS_MIN:  rd_mux = {1'b0, view_q.min};
        OFS_HOUR: rd_mux = {kick_q, 1'b0, view_q.hr};
        OFS_DOW:  rd_mux = {1'b0, ftest_q, 3'b000, view_q.dow};
        OFS_DATE: rd_mux = {2'b00, view_q.date};
        OFS_MON:  rd_mux = {3'b000, view_q.mon};
        OFS_YEAR: rd_mux = view_q.yr;
        default:  rd_mux = 8'h00;
      endcase
    end
  end

  assign rdata_d = rd_req ? rd_mux : bus_rdata;

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      live_q    <= TOD_RESET;
      stage_q   <= TOD_RESET;
      view_q    <= TOD_RESET;
      hold_q    <= 1'b0;
      freeze_q  <= 1'b0;
      pend_q    <= 1'b0;
      stop_q    <= 1'b0;
      kick_q    <= 1'b0;
      ftest_q   <= 1'b0;
      cal_q     <= '0;
      bus_rdata <= 8'h00;
    end else begin
      live_q    <= live_d;
      stage_q   <= stage_d;
      view_q    <= view_d;
      hold_q    <= hold_d;
      freeze_q  <= freeze_d;
      pend_q    <= pend_d;
      stop_q    <= stop_d;
      kick_q    <= kick_d;
      ftest_q   <= ftest_d;
      cal_q     <= cal_d;
      bus_rdata <= rdata_d;
    end
  end

  // ---------------- assertions ----------------
  AST_STOP_FREEZES_TIME: assert property (@(posedge clk) disable iff (!srst_n)
    (stop_q && !hold_q) |=> $stable(live_q)); // R7
  AST_HOLD_KEEPS_LIVE: assert property (@(posedge clk) disable iff (!srst_n)
    hold_q |=> (!hold_q || $stable(live_q))); // R8
  AST_PEND_GONE_WHEN_RUNNING: assert property (@(posedge clk) disable iff (!srst_n)
    (!hold_q && !hold_set) |=> !pend_q); // R9
  AST_FREEZE_KEEPS_VIEW: assert property (@(posedge clk) disable iff (!srst_n)
    freeze_q |=> $stable(view_q)); // R10
  AST_RDATA_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!srst_n)
    !(bus_en && !bus_we) |=> $stable(bus_rdata)); // R13

endmodule

// File: tb/tod_calendar_rf_tb.sv
module tod_calendar_rf_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 11;
  localparam logic [ADDR_W-1:0] BASE = {{(ADDR_W-3){1'b1}}, 3'b000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1hz = 1'b0;
  logic bus_en = 1'b0;
  logic bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_calendar_rf #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  // ---------------- behavioural reference model ----------------
  // index 0 sec, 1 min, 2 hour, 3 dow, 4 date, 5 month, 6 year (decimal integers)
  int t[7], s[7], v[7];
  int m_hold, m_frz, m_cal, m_stop, m_kick, m_ft, m_pend, m_rd;

  function automatic int b2d(int x); return (x / 16) * 10 + (x % 16); endfunction
  function automatic int d2b(int x); return (x / 10) * 16 + (x % 10); endfunction

  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic adv(inout int a[7]);
    a[0]++;
    if (a[0] > 59) begin
      a[0] = 0; a[1]++;
      if (a[1] > 59) begin
        a[1] = 0; a[2]++;
        if (a[2] > 23) begin
          a[2] = 0;
          a[3] = (a[3] == 7) ? 1 : a[3] + 1;
          a[4]++;
          if (a[4] > mdays(a[5], a[6])) begin
            a[4] = 1; a[5]++;
            if (a[5] > 12) begin a[5] = 1; a[6] = (a[6] + 1) % 100; end
          end
        end
      end
    end
  endtask

  function automatic int mread(int off);
    case (off)
      0: return m_hold * 128 + m_frz * 64 + m_cal;
      1: return m_stop * 128 + d2b(v[0]);
      2: return d2b(v[1]);
      3: return m_kick * 128 + d2b(v[2]);
      4: return m_ft * 64 + v[3];
      5: return d2b(v[4]);
      6: return d2b(v[5]);
      default: return d2b(v[6]);
    endcase
  endfunction

  task automatic mreset();
    t = '{0, 0, 0, 1, 1, 1, 0};
    s = t; v = t;
    m_hold = 0; m_frz = 0; m_cal = 0; m_stop = 0; m_kick = 0; m_ft = 0; m_pend = 0; m_rd = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mreset();
    end else begin
      int nt[7], ns[7], nv[7];
      int tk, off, inwin, wr, wrc, nh, np;
      int mask[7];
      mask = '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
      nt = t; ns = s; nv = m_frz ? v : t;
      tk    = (tick_1hz && !m_stop) ? 1 : 0;
      inwin = (bus_addr[ADDR_W-1:3] == '1) ? 1 : 0;
      off   = int'(bus_addr[2:0]);
      wr    = (bus_en && bus_we && inwin) ? 1 : 0;
      wrc   = (wr && off == 0) ? 1 : 0;
      nh    = wrc ? int'(bus_wdata[7]) : m_hold;
      np    = m_pend;
      if (bus_en && !bus_we) m_rd = inwin ? mread(off) : 0;
      if (!m_hold) begin
        if (nh) begin ns = t; np = tk; end
        else if (tk) adv(nt);
      end else if (!nh) begin
        nt = s;
        if (m_pend || tk) adv(nt);
        np = 0;
      end else begin
        if (tk) np = 1;
        if (wr && off != 0) ns[off-1] = b2d(int'(bus_wdata) & mask[off-1]);
      end
      if (wrc) begin m_frz = int'(bus_wdata[6]); m_cal = int'(bus_wdata[5:0]); end
      if (wr && off == 1) m_stop = int'(bus_wdata[7]);
      if (wr && off == 3) m_kick = int'(bus_wdata[7]);
      if (wr && off == 4) m_ft   = int'(bus_wdata[6]);
      m_hold = nh; m_pend = np;
      t = nt; s = ns; v = nv;
    end
  end

  // per-cycle comparison of read data with the model (R13)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (int'(bus_rdata) != m_rd) begin
        errors++;
        $display("FAIL R13 model compare: actual %02h expected %02h at %0t", bus_rdata, m_rd[7:0], $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string tag);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %03h: actual %02h expected %02h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic pulse();
    tick_1hz = 1; @(negedge clk); tick_1hz = 0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic load(input logic [7:0] sc, mn, hr, dw, dt, mo, yr);
    wr_reg(BASE + 0, 8'h80);
    wr_reg(BASE + 1, sc); wr_reg(BASE + 2, mn); wr_reg(BASE + 3, hr);
    wr_reg(BASE + 4, dw); wr_reg(BASE + 5, dt); wr_reg(BASE + 6, mo);
    wr_reg(BASE + 7, yr);
    wr_reg(BASE + 0, 8'h00);
    @(negedge clk); @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset values, R2 map order
    rd_chk(BASE + 0, 8'h00, "R1 ctrl");
    rd_chk(BASE + 1, 8'h00, "R1 sec");
    rd_chk(BASE + 2, 8'h00, "R1 min");
    rd_chk(BASE + 3, 8'h00, "R1 hour");
    rd_chk(BASE + 4, 8'h01, "R1 dow");
    rd_chk(BASE + 5, 8'h01, "R1 date");
    rd_chk(BASE + 6, 8'h01, "R1 month");
    rd_chk(BASE + 7, 8'h00, "R1 year");
    wr_reg(11'h7F0, 8'h55);
    rd_chk(11'h7F0, 8'h00, "R2 outside window");
    rd_chk(11'h000, 8'h00, "R2 low address");

    // R3/R4/R5: common-year February end at midnight
    load(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    rd_chk(BASE + 1, 8'h58, "R8 loaded seconds");
    pulse();
    rd_chk(BASE + 1, 8'h59, "R3 seconds step");
    pulse();
    rd_chk(BASE + 1, 8'h00, "R3 seconds wrap");
    rd_chk(BASE + 2, 8'h00, "R3 minutes wrap");
    rd_chk(BASE + 3, 8'h00, "R3 hours wrap");
    rd_chk(BASE + 4, 8'h01, "R4 dow 07 to 01");
    rd_chk(BASE + 5, 8'h01, "R6 common Feb 28 end");
    rd_chk(BASE + 6, 8'h03, "R5 month carry");

    // R6 leap year
    load(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    pulse();
    rd_chk(BASE + 5, 8'h29, "R6 leap Feb 29");
    rd_chk(BASE + 4, 8'h04, "R4 dow step");
    load(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
    pulse();
    rd_chk(BASE + 5, 8'h01, "R6 leap Feb end");
    rd_chk(BASE + 6, 8'h03, "R6 leap month carry");

    // R5 30-day month and year wrap
    load(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h24);
    pulse();
    rd_chk(BASE + 5, 8'h01, "R5 30-day month end");
    rd_chk(BASE + 6, 8'h05, "R5 month after April");
    load(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
    pulse();
    rd_chk(BASE + 6, 8'h01, "R5 December wrap");
    rd_chk(BASE + 7, 8'h00, "R5 year 99 wrap");
    rd_chk(BASE + 4, 8'h07, "R4 dow to 07");

    // R7 stop flag; R8 field ignored without hold
    wr_reg(BASE + 1, 8'hB3);
    rd_chk(BASE + 1, 8'h80, "R8 field ignored, R7 stop set");
    pulse(); pulse();
    rd_chk(BASE + 1, 8'h80, "R7 stopped seconds");
    wr_reg(BASE + 1, 8'h00);
    pulse();
    rd_chk(BASE + 1, 8'h01, "R7 running again");

    // R10 freeze
    wr_reg(BASE + 0, 8'h40);
    rd_chk(BASE + 0, 8'h40, "R10 freeze readback");
    pulse(); pulse();
    rd_chk(BASE + 1, 8'h01, "R10 frozen view");
    wr_reg(BASE + 0, 8'h00);
    @(negedge clk);
    rd_chk(BASE + 1, 8'h03, "R10 view refreshed");
    @(negedge clk);
    checks++;
    if (bus_rdata !== 8'h03) begin
      errors++;
      $display("FAIL R13 hold after read: actual %02h expected 03", bus_rdata);
    end

    // R9 tick during hold
    wr_reg(BASE + 0, 8'h80);
    rd_chk(BASE + 0, 8'h80, "R8 hold readback");
    wr_reg(BASE + 1, 8'h10);
    wr_reg(BASE + 2, 8'h45);
    pulse();
    rd_chk(BASE + 1, 8'h03, "R8 counters held");
    wr_reg(BASE + 0, 8'h00);
    @(negedge clk); @(negedge clk);
    rd_chk(BASE + 1, 8'h11, "R9 pending tick applied");
    rd_chk(BASE + 2, 8'h45, "R8 staged minutes");

    // R11 kick-start and frequency-test flags
    wr_reg(BASE + 3, 8'h80);
    rd_chk(BASE + 3, 8'h80, "R11 kick flag");
    wr_reg(BASE + 4, 8'h40);
    rd_chk(BASE + 4, 8'h47, "R11 freq-test flag");
    pulse();
    rd_chk(BASE + 3, 8'h80, "R11 kick kept by counting");
    rd_chk(BASE + 1, 8'h12, "R11 counting with flags");

    // R12 calibration bits stored, no effect
    wr_reg(BASE + 0, 8'h2A);
    rd_chk(BASE + 0, 8'h2A, "R12 calibration readback");
    pulse();
    rd_chk(BASE + 1, 8'h13, "R12 counting unaffected");
    wr_reg(BASE + 5, 8'hFF);
    rd_chk(BASE + 5, 8'h01, "R12 spare date bits zero");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule